// File: doc/BRIEF.md
# Dual-Counter Raster Timing Generator

This block produces the raster timing for one display output from a single system clock. Inside it run two independent position counters, each a pair of horizontal and vertical counters. The fetch counter starts as soon as the block is enabled. It raises a fetch trigger over its active area, so that pixel reads from memory can begin ahead of the screen.

The display counter can wait for an external reference pulse. That pulse marks where the screen should start, after the latency of the blocks between the memory and the output. The display counter drives the horizontal and vertical sync, the horizontal and vertical active flags, the data enable and the frame-end pulse.

The raster is chosen at elaboration by a format number and a pixels-per-clock value. Every segment length can also be overridden directly. All outputs are registered.

Top module: `vtg_dual_raster`

## Requirements
- R1: A display line lasts H_TOT = H_ACT+H_FP+H_SW+H_BP cycles. Within a line the segments come in the order active, front porch, sync, back porch. hact_o is high for the first H_ACT cycles of each line. hsync_o (active high) is high for the H_SW cycles that begin H_ACT+H_FP cycles after line start.
- R2: A frame lasts V_TOT = V_ACT+V_FP+V_SW+V_BP lines, in the same segment order. vact_o is high during the first V_ACT lines. vsync_o (active high) is high for the V_SW lines that begin after V_ACT+V_FP lines. The line number changes only when a line ends.
- R3: de_o equals hact_o AND vact_o in every cycle.
- R4: The fetch counter sits at position (0,0) after the first edge at which en_i is sampled high. fetch_trig_o follows one edge later. It is high whenever the fetch position lies inside both active ranges, and it repeats every H_TOT cycles and V_TOT lines.
- R5: With ext_sync_en_i high, the display counter stays idle until ext_sync_i is sampled high together with en_i. From the following cycle its position is (0,0), and its outputs appear one edge after that. While it runs, further ext_sync_i pulses have no effect on any output.
- R6: With ext_sync_en_i low, the display counter starts at the same edge as the fetch counter. In that case de_o matches fetch_trig_o in every cycle.
- R7: frame_end_o is high for exactly one cycle per frame. That cycle is the first cycle of the next display frame, when the display position has returned to (0,0).
- R8: When en_i is sampled low, every output except hres_o is low after that edge and both counters return to zero. A later enable restarts them as R4 and R5 describe.
- R9: rst is synchronous and active high. After an edge with rst high, every output except hres_o is low and both counters are idle at zero.
- R10: hres_o is a constant 16-bit value equal to H_ACT.
- R11: FORMAT picks the default timing: 0 is 1280x720 (H 1280/110/40/220, V 720/5/5/20), 1 is 1920x1080 (H 1920/88/44/148, V 1080/4/5/36), 2 is 3840x2160 (H 3840/176/88/296, V 2160/8/10/72). PPC=4 divides each horizontal value by four, rounding down. So FORMAT 1 with PPC 4 gives hres_o 480, and FORMAT 2 with PPC 4 gives 960.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Runs both counters; low clears them |
| ext_sync_en_i | input | 1 | Display counter waits for ext_sync_i when high |
| ext_sync_i | input | 1 | External reference marking the display start |
| hsync_o | output | 1 | Horizontal sync, active high |
| vsync_o | output | 1 | Vertical sync, active high |
| hact_o | output | 1 | Horizontal active period |
| vact_o | output | 1 | Vertical active period |
| de_o | output | 1 | Data enable |
| fetch_trig_o | output | 1 | Early trigger for pixel memory reads |
| frame_end_o | output | 1 | One-cycle pulse at each display frame boundary |
| hres_o | output | 16 | Horizontal active width |

## Verification
A wrong display position moves hact_o or hsync_o within one cycle. A miscounted line wrap therefore shows up at the latest at the end of the first line. A wrong line counter shows on vact_o, vsync_o or frame_end_o within one line time. A start condition that is wrong for either counter shifts fetch_trig_o against de_o from the first active pixel onward. The bench compares every output in every cycle against a model built from the requirements, so such a shift is reported the cycle it happens.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

  typedef enum int {SEG_ACT = 0, SEG_FP = 1, SEG_SYNC = 2, SEG_BP = 3} seg_e;

  // Horizontal segment length in clocks, divided by pixels per clock.
  function automatic int h_seg(int fmt, int ppc, seg_e s);
    int v;
    case (fmt)
      0:       case (s) SEG_ACT: v = 1280; SEG_FP: v = 110; SEG_SYNC: v = 40; default: v = 220; endcase
      1:       case (s) SEG_ACT: v = 1920; SEG_FP: v = 88;  SEG_SYNC: v = 44; default: v = 148; endcase
      default: case (s) SEG_ACT: v = 3840; SEG_FP: v = 176; SEG_SYNC: v = 88; default: v = 296; endcase
    endcase
    return v / ((ppc < 1) ? 1 : ppc);
  endfunction

  // Vertical segment length in lines.
  function automatic int v_seg(int fmt, seg_e s);
    int v;
    case (fmt)
      0:       case (s) SEG_ACT: v = 720;  SEG_FP: v = 5; SEG_SYNC: v = 5;  default: v = 20; endcase
      1:       case (s) SEG_ACT: v = 1080; SEG_FP: v = 4; SEG_SYNC: v = 5;  default: v = 36; endcase
      default: case (s) SEG_ACT: v = 2160; SEG_FP: v = 8; SEG_SYNC: v = 10; default: v = 72; endcase
    endcase
    return v;
  endfunction

endpackage

// File: rtl/vtg_raster_counter.sv
module vtg_raster_counter #(
  parameter int H_TOT = 17,
  parameter int V_TOT = 10,
  parameter int HW    = 5,
  parameter int VW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          start,
  output logic          run_o,
  output logic [HW-1:0] h_o,
  output logic [VW-1:0] v_o
);
  localparam logic [HW-1:0] H_LAST = HW'(H_TOT - 1);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOT - 1);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      run_o <= 1'b0;
      h_o   <= '0;
      v_o   <= '0;
    end else if (!run_o) begin
      run_o <= start;              // position stays (0,0) until armed
    end else if (h_o == H_LAST) begin
      h_o <= '0;
      v_o <= (v_o == V_LAST) ? '0 : v_o + 1'b1;
    end else begin
      h_o <= h_o + 1'b1;
    end
  end
endmodule

// File: rtl/vtg_raster_decode.sv
module vtg_raster_decode #(
  parameter int H_ACT = 8,
  parameter int H_FP  = 2,
  parameter int H_SW  = 3,
  parameter int H_TOT = 17,
  parameter int V_ACT = 4,
  parameter int V_FP  = 1,
  parameter int V_SW  = 2,
  parameter int V_TOT = 10,
  parameter int HW    = 5,
  parameter int VW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          run,
  input  logic [HW-1:0] h,
  input  logic [VW-1:0] v,
  output logic          hact_o,
  output logic          vact_o,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic          fend_o
);
  localparam logic [HW-1:0] HA  = HW'(H_ACT);
  localparam logic [HW-1:0] HSB = HW'(H_ACT + H_FP);
  localparam logic [HW-1:0] HSE = HW'(H_ACT + H_FP + H_SW);
  localparam logic [HW-1:0] HL  = HW'(H_TOT - 1);
  localparam logic [VW-1:0] VA  = VW'(V_ACT);
  localparam logic [VW-1:0] VSB = VW'(V_ACT + V_FP);
  localparam logic [VW-1:0] VSE = VW'(V_ACT + V_FP + V_SW);
  localparam logic [VW-1:0] VL  = VW'(V_TOT - 1);

  logic ha_c, va_c, hs_c, vs_c, fe_c;

  always_comb begin
    ha_c = run && (h < HA);
    va_c = run && (v < VA);
    hs_c = run && (h >= HSB) && (h < HSE);
    vs_c = run && (v >= VSB) && (v < VSE);
    fe_c = run && (h == HL) && (v == VL);
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      hact_o  <= 1'b0;
      vact_o  <= 1'b0;
      hsync_o <= 1'b0;
      vsync_o <= 1'b0;
      de_o    <= 1'b0;
      fend_o  <= 1'b0;
    end else begin
      hact_o  <= ha_c;
      vact_o  <= va_c;
      hsync_o <= hs_c;
      vsync_o <= vs_c;
      de_o    <= ha_c && va_c;
      fend_o  <= fe_c;
    end
  end
endmodule

// File: rtl/vtg_dual_raster.sv
module vtg_dual_raster
  import vtg_pkg::*;
#(
  parameter int FORMAT = 1,
  parameter int PPC    = 1,
  parameter int H_ACT  = h_seg(FORMAT, PPC, SEG_ACT),
  parameter int H_FP   = h_seg(FORMAT, PPC, SEG_FP),
  parameter int H_SW   = h_seg(FORMAT, PPC, SEG_SYNC),
  parameter int H_BP   = h_seg(FORMAT, PPC, SEG_BP),
  parameter int V_ACT  = v_seg(FORMAT, SEG_ACT),
  parameter int V_FP   = v_seg(FORMAT, SEG_FP),
  parameter int V_SW   = v_seg(FORMAT, SEG_SYNC),
  parameter int V_BP   = v_seg(FORMAT, SEG_BP)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        en_i,
  input  logic        ext_sync_en_i,
  input  logic        ext_sync_i,
  output logic        hsync_o,
  output logic        vsync_o,
  output logic        hact_o,
  output logic        vact_o,
  output logic        de_o,
  output logic        fetch_trig_o,
  output logic        frame_end_o,
  output logic [15:0] hres_o
);
  localparam int H_TOT = H_ACT + H_FP + H_SW + H_BP;
  localparam int V_TOT = V_ACT + V_FP + V_SW + V_BP;
  localparam int HW    = $clog2(H_TOT + 1);
  localparam int VW    = $clog2(V_TOT + 1);
  localparam logic [HW-1:0] FHA = HW'(H_ACT);
  localparam logic [VW-1:0] FVA = VW'(V_ACT);

  logic          fetch_run;
  logic [HW-1:0] fetch_h;
  logic [VW-1:0] fetch_v;
  logic          disp_run;
  logic [HW-1:0] disp_h;
  logic [VW-1:0] disp_v;
  logic          disp_start;

  assign disp_start = ext_sync_en_i ? ext_sync_i : 1'b1;

  vtg_raster_counter #(.H_TOT(H_TOT), .V_TOT(V_TOT), .HW(HW), .VW(VW)) u_fetch_cnt (
    .clk(clk), .rst(rst), .en(en_i), .start(1'b1),
    .run_o(fetch_run), .h_o(fetch_h), .v_o(fetch_v)
  );

  vtg_raster_counter #(.H_TOT(H_TOT), .V_TOT(V_TOT), .HW(HW), .VW(VW)) u_disp_cnt (
    .clk(clk), .rst(rst), .en(en_i), .start(disp_start),
    .run_o(disp_run), .h_o(disp_h), .v_o(disp_v)
  );

  vtg_raster_decode #(
    .H_ACT(H_ACT), .H_FP(H_FP), .H_SW(H_SW), .H_TOT(H_TOT),
    .V_ACT(V_ACT), .V_FP(V_FP), .V_SW(V_SW), .V_TOT(V_TOT),
    .HW(HW), .VW(VW)
  ) u_disp_dec (
    .clk(clk), .rst(rst), .en(en_i), .run(disp_run), .h(disp_h), .v(disp_v),
    .hact_o(hact_o), .vact_o(vact_o), .hsync_o(hsync_o), .vsync_o(vsync_o),
    .de_o(de_o), .fend_o(frame_end_o)
  );

  always_ff @(posedge clk) begin
    if (rst || !en_i) fetch_trig_o <= 1'b0;
    else              fetch_trig_o <= fetch_run && (fetch_h < FHA) && (fetch_v < FVA);
  end

  assign hres_o = 16'(H_ACT);
endmodule

// File: rtl/vtg_dual_raster_checker.sv
module vtg_dual_raster_checker #(
  parameter int H_TOT = 17,
  parameter int V_TOT = 10,
  parameter int HW    = 5,
  parameter int VW    = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          en_i,
  input logic          disp_run,
  input logic [HW-1:0] disp_h,
  input logic [VW-1:0] disp_v,
  input logic          hsync_o,
  input logic          vsync_o,
  input logic          hact_o,
  input logic          vact_o,
  input logic          de_o,
  input logic          fetch_trig_o,
  input logic          frame_end_o
);
  localparam logic [HW-1:0] HL = HW'(H_TOT - 1);
  localparam logic [VW-1:0] VL = VW'(V_TOT - 1);

  assert_line_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    (en_i && disp_run && disp_h == HL) |=> (disp_h == '0));

  assert_frame_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    (en_i && disp_run && disp_h == HL && disp_v == VL) |=> (disp_v == '0));

  assert_line_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (en_i && disp_run && disp_h != HL) |=> $stable(disp_v));

  assert_vsync_blank_R2: assert property (@(posedge clk) disable iff (rst)
    vsync_o |-> !vact_o);

  assert_de_gate_R3: assert property (@(posedge clk) disable iff (rst)
    de_o |-> (hact_o && vact_o));

  assert_fend_single_R7: assert property (@(posedge clk) disable iff (rst)
    frame_end_o |=> !frame_end_o);

  assert_quiet_off_R8: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !(hsync_o || vsync_o || hact_o || vact_o || de_o || fetch_trig_o || frame_end_o));

  assert_reset_clear_R9: assert property (@(posedge clk)
    rst |=> !(hsync_o || vsync_o || hact_o || vact_o || de_o || fetch_trig_o || frame_end_o || disp_run));
endmodule

bind vtg_dual_raster vtg_dual_raster_checker #(
  .H_TOT(H_TOT), .V_TOT(V_TOT), .HW(HW), .VW(VW)
) u_chk (
  .clk(clk), .rst(rst), .en_i(en_i),
  .disp_run(disp_run), .disp_h(disp_h), .disp_v(disp_v),
  .hsync_o(hsync_o), .vsync_o(vsync_o), .hact_o(hact_o), .vact_o(vact_o),
  .de_o(de_o), .fetch_trig_o(fetch_trig_o), .frame_end_o(frame_end_o)
);

// File: tb/vtg_dual_raster_bench.sv
module vtg_dual_raster_bench;
  localparam int HA = 8, HF = 2, HS = 3, HB = 4;
  localparam int VA = 4, VF = 1, VS = 2, VB = 3;
  localparam int HT = HA + HF + HS + HB;
  localparam int VT = VA + VF + VS + VB;

  typedef struct packed {
    logic hs, vs, ha, va, de, tr, fe;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0, xen = 1'b0, xs = 1'b0;
  logic hs, vs, ha, va, de, tr, fe;
  logic [15:0] hres;
  logic [15:0] hres_q4, hres_720, hres_2160q;
  logic d1 [7], d2 [7], d3 [7];

  int checks = 0;
  int fails = 0;
  string tag = "R9";
  exp_t q[$];

  // model state
  bit a_run, b_run;
  int ah, av, bh, bv;

  always #4 clk = ~clk;

  vtg_dual_raster #(
    .H_ACT(HA), .H_FP(HF), .H_SW(HS), .H_BP(HB),
    .V_ACT(VA), .V_FP(VF), .V_SW(VS), .V_BP(VB)
  ) u_vtg_dual_raster (
    .clk(clk), .rst(rst), .en_i(en), .ext_sync_en_i(xen), .ext_sync_i(xs),
    .hsync_o(hs), .vsync_o(vs), .hact_o(ha), .vact_o(va), .de_o(de),
    .fetch_trig_o(tr), .frame_end_o(fe), .hres_o(hres)
  );

  vtg_dual_raster #(.FORMAT(1), .PPC(4)) u_vtg_q4 (
    .clk(clk), .rst(rst), .en_i(1'b0), .ext_sync_en_i(1'b0), .ext_sync_i(1'b0),
    .hsync_o(d1[0]), .vsync_o(d1[1]), .hact_o(d1[2]), .vact_o(d1[3]), .de_o(d1[4]),
    .fetch_trig_o(d1[5]), .frame_end_o(d1[6]), .hres_o(hres_q4)
  );

  vtg_dual_raster #(.FORMAT(0), .PPC(1)) u_vtg_720 (
    .clk(clk), .rst(rst), .en_i(1'b0), .ext_sync_en_i(1'b0), .ext_sync_i(1'b0),
    .hsync_o(d2[0]), .vsync_o(d2[1]), .hact_o(d2[2]), .vact_o(d2[3]), .de_o(d2[4]),
    .fetch_trig_o(d2[5]), .frame_end_o(d2[6]), .hres_o(hres_720)
  );

  vtg_dual_raster #(.FORMAT(2), .PPC(4)) u_vtg_2160q (
    .clk(clk), .rst(rst), .en_i(1'b0), .ext_sync_en_i(1'b0), .ext_sync_i(1'b0),
    .hsync_o(d3[0]), .vsync_o(d3[1]), .hact_o(d3[2]), .vact_o(d3[3]), .de_o(d3[4]),
    .fetch_trig_o(d3[5]), .frame_end_o(d3[6]), .hres_o(hres_2160q)
  );

  task automatic step_pos(inout int h, inout int v);
    if (h == HT - 1) begin
      h = 0;
      v = (v == VT - 1) ? 0 : v + 1;
    end else h = h + 1;
  endtask

  // Driver side of the scoreboard: predicts the outputs of this edge from the requirements.
  task automatic predict_edge();
    exp_t e;
    e = '0;
    if (!(rst || !en)) begin
      e.ha = b_run && bh < HA;
      e.hs = b_run && bh >= HA + HF && bh < HA + HF + HS;
      e.va = b_run && bv < VA;
      e.vs = b_run && bv >= VA + VF && bv < VA + VF + VS;
      e.de = e.ha && e.va;
      e.tr = a_run && ah < HA && av < VA;
      e.fe = b_run && bh == HT - 1 && bv == VT - 1;
    end
    q.push_back(e);
    if (rst || !en) begin
      a_run = 0; b_run = 0; ah = 0; av = 0; bh = 0; bv = 0;
    end else begin
      if (a_run) step_pos(ah, av); else a_run = 1;
      if (b_run) step_pos(bh, bv); else b_run = xen ? xs : 1'b1;
    end
  endtask

  always @(posedge clk) predict_edge();

  task automatic cmp(string name, string req, logic act, logic exp);
    if (act !== exp) begin
      fails++;
      $display("FAIL %s/%s %s act=%b exp=%b t=%0t", tag, req, name, act, exp, $time);
    end
  endtask

  // Monitor: pops one expected item per cycle and compares away from the edge.
  always @(negedge clk) begin
    exp_t e;
    int f0;
    if (q.size() > 0) begin
      e = q.pop_front();
      f0 = fails;
      checks++;
      cmp("hact", "R1", ha, e.ha);
      cmp("hsync", "R1", hs, e.hs);
      cmp("vact", "R2", va, e.va);
      cmp("vsync", "R2", vs, e.vs);
      cmp("de", "R3", de, e.de);
      cmp("trig", "R4", tr, e.tr);
      cmp("fend", "R7", fe, e.fe);
      if (fails > f0) fails = f0 + 1;
    end
  end

  task automatic chk16(string req, string name, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d", req, name, act, exp);
    end
  endtask

  task automatic wait_cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R9: reset state
    tag = "R9";
    wait_cycles(5);
    rst = 1'b0;
    wait_cycles(3);
    // R10 / R11: constant width outputs
    chk16("R10", "hres", hres, 16'd8);
    chk16("R11", "hres 1080p ppc4", hres_q4, 16'd480);
    chk16("R11", "hres 720p ppc1", hres_720, 16'd1280);
    chk16("R11", "hres 2160p ppc4", hres_2160q, 16'd960);

    // R6: both counters start together when the external reference is unused
    tag = "R6";
    en = 1'b1;
    wait_cycles(2 * HT * VT + 7);

    // R8: disable clears everything, then restart
    tag = "R8";
    en = 1'b0;
    wait_cycles(12);

    // R5: display waits for the external reference
    tag = "R5";
    xen = 1'b1;
    en = 1'b1;
    wait_cycles(23);
    xs = 1'b1;
    wait_cycles(1);
    xs = 1'b0;
    wait_cycles(HT * VT + 40);
    xs = 1'b1;                 // ignored while running
    wait_cycles(2);
    xs = 1'b0;
    wait_cycles(HT * VT + 5);

    // R9: mid-run reset, then re-arm from the reference
    tag = "R9";
    rst = 1'b1;
    wait_cycles(3);
    rst = 1'b0;
    wait_cycles(9);
    tag = "R5";
    xs = 1'b1;
    wait_cycles(1);
    xs = 1'b0;
    wait_cycles(HT * VT + 20);

    // R8: drop enable while the reference is armed
    tag = "R8";
    en = 1'b0;
    wait_cycles(6);
    en = 1'b1;
    wait_cycles(30);
    wait_cycles(2);
    finish_run();
  end
endmodule